// File: doc/BRIEF.md
# Interrupt Status Flag Aggregator

This block holds the general interrupt status of a serial bus controller. Seven event pulses from the protocol engine each set a sticky flag. These events are receive FIFO overrun, message format error, sync pulse too early, sync pulse too late, illegal pulse, lock loss and wakeup. An eighth flag reports transmit readiness. The block computes it live from the per-buffer interrupt flags, masked by the per-buffer enables. It is never stored as a sticky bit.

A CPU register port with a one-bit select reaches two registers: the status word and an eight-bit enable word. The CPU clears a sticky flag by writing 1 to its position. A registered interrupt request is the OR of every flag ANDed with its enable. The port has no data stream, so it has no valid/ready handshake. Writes are single-cycle strobes and are never stalled. Reads are combinational from registers.

A synchronous soft reset clears the sticky flags and leaves the enables as they are. It also forces the transmit flag high if any transmit buffer is configured. An asynchronous hard reset clears everything.

Top module: `irq_status_agg`

## Requirements
- R1: After hard reset, the status word (select 0) and the enable word (select 1) both read 0, and `irq` is 0.
- R2: The status word holds these bits: bit 7 transmit, bit 6 overrun, bit 5 format error, bit 4 sync too early, bit 3 sync too late, bit 2 illegal pulse, bit 1 lock, bit 0 wakeup. A 1 on `ev_pulse[i]` (i = 0..6) at a clock edge sets status bit i. The bit then stays set after the pulse ends.
- R3: A write with select 0 clears each sticky bit whose data bit is 1. Data bits that are 0 change nothing. Data bit 7 has no effect on the transmit flag.
- R4: When a set pulse and a write-1 clear reach the same sticky bit at the same edge, the bit ends up set.
- R5: Status bit 7 is 1, with no clock delay, whenever some buffer has both `txb_flag[n]` and `txb_ien[n]` at 1. A buffer whose `txb_ien[n]` is 0 does not raise it.
- R6: When the last enabled buffer flag falls, status bit 7 stays 1 through the first clock edge after the fall. It reads 0 after the second edge.
- R7: `irq` at each edge takes the OR over bits of (status AND enable word) as it stood before that edge, so it lags by one cycle. Enable bit 7 gates the transmit flag. Enable bit i gates sticky bit i.
- R8: A cycle with `soft_rst` high clears all sticky bits at the next edge and leaves the enable word unchanged. If any `txb_cfg` bit is 1, status bit 7 reads 1 after that edge and after the next one. It then follows R5/R6 and reads 0 after the second edge when no enabled buffer flag is set.
- R9: A soft reset with all `txb_cfg` bits at 0 and no enabled buffer flag set leaves status bit 7 at 0.
- R10: Driving `hard_rst_n` low clears status, enables and `irq` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| ev_pulse | input | 7 | Event pulses, bit i sets status bit i |
| txb_flag | input | NUM_TXBUF | Per-buffer transmit interrupt flags (1 = empty) |
| txb_ien | input | NUM_TXBUF | Per-buffer interrupt enables |
| txb_cfg | input | NUM_TXBUF | Per-buffer configured-as-transmit indication |
| cpu_sel | input | 1 | Register select: 0 status, 1 enable word |
| cpu_wr_en | input | 1 | Single-cycle write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered general interrupt request |

## Verification
A sticky bit that is lost or stuck shows on the status read one cycle after the event or clear that should have moved it. It shows on `irq` one cycle later still. A wrong depth in the transmit fall delay shows as bit 7 dropping one edge early or late after the last buffer flag clears, so the bench samples after each of the two edges. A soft reset that loses the enable word, or that gets the configured-buffer rule wrong, shows in the first read after the reset edge.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;
  localparam int FLAG_W   = 8;
  localparam int STICKY_W = FLAG_W - 1;
  localparam int TX_BIT   = FLAG_W - 1;
  localparam int TX_DELAY = 2;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_sticky_bank.sv
`timescale 1ns/1ps
module irq_sticky_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (soft_clr) q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_tx_flag.sv
`timescale 1ns/1ps
module irq_tx_flag #(
  parameter int N     = 4,
  parameter int DELAY = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] buf_flag,
  input  logic [N-1:0] buf_ien,
  input  logic [N-1:0] buf_cfg,
  output logic         live_o,
  output logic         tx_o
);
  logic [DELAY-1:0] hold_q;

  assign live_o = |(buf_flag & buf_ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (soft_rst) hold_q <= {DELAY{|buf_cfg}};
    else               hold_q <= {hold_q[DELAY-2:0], live_o};
  end

  // rises at once, falls DELAY edges after the live term drops
  assign tx_o = live_o | (|hold_q);
endmodule

// File: rtl/irq_req_gen.sv
`timescale 1ns/1ps
module irq_req_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(flags & enables);
  end
endmodule

// File: rtl/irq_status_agg.sv
`timescale 1ns/1ps
module irq_status_agg
  import irq_status_pkg::*;
#(
  parameter int NUM_TXBUF = 4
) (
  input  logic                 clk,
  input  logic                 hard_rst_n,
  input  logic                 soft_rst,
  input  logic [STICKY_W-1:0]  ev_pulse,
  input  logic [NUM_TXBUF-1:0] txb_flag,
  input  logic [NUM_TXBUF-1:0] txb_ien,
  input  logic [NUM_TXBUF-1:0] txb_cfg,
  input  logic                 cpu_sel,
  input  logic                 cpu_wr_en,
  input  logic [FLAG_W-1:0]    cpu_wdata,
  output logic [FLAG_W-1:0]    cpu_rdata,
  output logic                 irq
);
  logic [STICKY_W-1:0] sticky_q;
  logic [STICKY_W-1:0] clr_vec;
  logic [FLAG_W-1:0]   en_q;
  logic [FLAG_W-1:0]   status_w;
  logic                tx_flag;
  logic                tx_live;
  logic                wr_status, wr_enable;

  assign wr_status = cpu_wr_en && (cpu_sel == SEL_STATUS);
  assign wr_enable = cpu_wr_en && (cpu_sel == SEL_ENABLE);
  assign clr_vec   = wr_status ? cpu_wdata[STICKY_W-1:0] : '0;

  irq_sticky_bank #(.W(STICKY_W)) u_sticky (
    .clk      (clk),
    .rst_n    (hard_rst_n),
    .soft_clr (soft_rst),
    .set_i    (ev_pulse),
    .clr_i    (clr_vec),
    .q        (sticky_q)
  );

  irq_tx_flag #(.N(NUM_TXBUF), .DELAY(TX_DELAY)) u_tx (
    .clk      (clk),
    .rst_n    (hard_rst_n),
    .soft_rst (soft_rst),
    .buf_flag (txb_flag),
    .buf_ien  (txb_ien),
    .buf_cfg  (txb_cfg),
    .live_o   (tx_live),
    .tx_o     (tx_flag)
  );

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)    en_q <= '0;
    else if (wr_enable) en_q <= cpu_wdata;
  end

  assign status_w  = {tx_flag, sticky_q};
  assign cpu_rdata = (cpu_sel == SEL_ENABLE) ? en_q : status_w;

  irq_req_gen #(.W(FLAG_W)) u_req (
    .clk     (clk),
    .rst_n   (hard_rst_n),
    .flags   (status_w),
    .enables (en_q),
    .irq_o   (irq)
  );
endmodule

// File: rtl/irq_status_chk.sv
`timescale 1ns/1ps
module irq_status_chk #(
  parameter int NUM_TXBUF = 4
) (
  input logic                 clk,
  input logic                 hard_rst_n,
  input logic                 soft_rst,
  input logic [6:0]           ev_pulse,
  input logic [NUM_TXBUF-1:0] txb_flag,
  input logic [NUM_TXBUF-1:0] txb_ien,
  input logic [NUM_TXBUF-1:0] txb_cfg,
  input logic                 cpu_sel,
  input logic                 cpu_wr_en,
  input logic [7:0]           cpu_wdata,
  input logic [7:0]           status,
  input logic [7:0]           enables,
  input logic                 irq
);
  logic armed;
  logic live;
  logic clr_any;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  assign live    = |(txb_flag & txb_ien);
  assign clr_any = cpu_wr_en && !cpu_sel && (|cpu_wdata[6:0]);

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (armed && $past(!soft_rst && !clr_any)) |->
      ((status[6:0] & $past(status[6:0])) == $past(status[6:0])));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (armed && $past(!soft_rst)) |->
      ((status[6:0] & $past(ev_pulse)) == $past(ev_pulse)));

  assert_tx_live_R5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    live |-> status[7]);

  assert_tx_fall_delay_R6: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (armed && $past(live)) |-> status[7]);

  assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    armed |-> (irq == $past(|(status & enables))));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (armed && $past(soft_rst)) |->
      ((status[6:0] == 7'd0) && (enables == $past(enables)) &&
       (status[7] == ($past(|txb_cfg) | live))));
endmodule

bind irq_status_agg irq_status_chk #(.NUM_TXBUF(NUM_TXBUF)) u_chk (
  .clk        (clk),
  .hard_rst_n (hard_rst_n),
  .soft_rst   (soft_rst),
  .ev_pulse   (ev_pulse),
  .txb_flag   (txb_flag),
  .txb_ien    (txb_ien),
  .txb_cfg    (txb_cfg),
  .cpu_sel    (cpu_sel),
  .cpu_wr_en  (cpu_wr_en),
  .cpu_wdata  (cpu_wdata),
  .status     (status_w),
  .enables    (en_q),
  .irq        (irq)
);

// File: tb/test_irq_status_agg.sv
`timescale 1ns/1ps
module test_irq_status_agg;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          hard_rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [6:0]    ev_pulse = '0;
  logic [NB-1:0] txb_flag = '0, txb_ien = '0, txb_cfg = '0;
  logic          cpu_sel = 1'b0, cpu_wr_en = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_status_agg #(.NUM_TXBUF(NB)) i_irq_status_agg (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .ev_pulse(ev_pulse),
    .txb_flag(txb_flag), .txb_ien(txb_ien), .txb_cfg(txb_cfg),
    .cpu_sel(cpu_sel), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq)
  );

  // {ev_pulse[6:0], wr_en, wdata[7:0], expected status[7:0]}
  localparam logic [23:0] VEC [7] = '{
    {7'h41, 1'b0, 8'h00, 8'h41},  // R2 set overrun + wakeup
    {7'h00, 1'b0, 8'h00, 8'h41},  // R2 held
    {7'h00, 1'b1, 8'h40, 8'h01},  // R3 clear overrun
    {7'h00, 1'b1, 8'h00, 8'h01},  // R3 zero write no effect
    {7'h01, 1'b1, 8'h01, 8'h01},  // R4 set beats clear
    {7'h3E, 1'b1, 8'h81, 8'h3E},  // R3 bit7 ignored, R2 sets
    {7'h00, 1'b1, 8'hFF, 8'h00}   // R3 clear all
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    cpu_sel = sel;
    #0.5;
    v = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  task automatic edge_sample;
    @(posedge clk);
    #1;
    ev_pulse = '0; cpu_wr_en = 1'b0; soft_rst = 1'b0;
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wr_en = 1'b1; cpu_wdata = d;
    edge_sample();
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rd(1'b0, v); check("R10 status in reset", v, 8'h00);
    hard_rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); check("R1 status", v, 8'h00);
    rd(1'b1, v); check("R1 enables", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      ev_pulse = VEC[k][23:17]; cpu_wr_en = VEC[k][16];
      cpu_sel = 1'b0; cpu_wdata = VEC[k][15:8];
      edge_sample();
      rd(1'b0, v); check($sformatf("R2/R3/R4 vec%0d", k), v, VEC[k][7:0]);
    end

    // R5 live transmit flag and masking
    @(negedge clk);
    txb_flag = 4'b0100; txb_ien = 4'b0010;
    #1; rd(1'b0, v); check("R5 masked buffer", v, 8'h00);
    txb_flag = 4'b0110;
    #1; rd(1'b0, v); check("R5 enabled buffer", v, 8'h80);
    @(posedge clk); @(posedge clk);

    // R6 fall two edges after last buffer flag clears
    @(negedge clk);
    txb_flag = 4'b0100;
    #1; rd(1'b0, v); check("R6 same cycle", v, 8'h80);
    edge_sample(); rd(1'b0, v); check("R6 after edge 1", v, 8'h80);
    edge_sample(); rd(1'b0, v); check("R6 after edge 2", v, 8'h00);

    // R7 registered request
    wr(1'b1, 8'h40);
    @(negedge clk); ev_pulse = 7'h40;
    edge_sample(); check("R7 lag", {7'd0, irq}, 8'h00);
    edge_sample(); check("R7 asserted", {7'd0, irq}, 8'h01);
    wr(1'b0, 8'h40);
    edge_sample(); check("R7 cleared", {7'd0, irq}, 8'h00);
    @(negedge clk); ev_pulse = 7'h01;
    edge_sample(); edge_sample(); check("R7 masked bit0", {7'd0, irq}, 8'h00);
    wr(1'b1, 8'h80);
    @(negedge clk); txb_flag = 4'b0010;
    edge_sample(); check("R7 tx enable", {7'd0, irq}, 8'h01);
    @(negedge clk); txb_flag = 4'b0000;
    edge_sample(); edge_sample(); edge_sample();
    check("R7 tx released", {7'd0, irq}, 8'h00);

    // R8 soft reset with configured buffer
    wr(1'b1, 8'hFF);
    @(negedge clk); ev_pulse = 7'h7F;
    edge_sample();
    @(negedge clk); txb_cfg = 4'b0001; soft_rst = 1'b1;
    edge_sample();
    rd(1'b0, v); check("R8 status after soft", v, 8'h80);
    rd(1'b1, v); check("R8 enables kept", v, 8'hFF);
    edge_sample(); rd(1'b0, v); check("R8 tx held", v, 8'h80);
    edge_sample(); rd(1'b0, v); check("R8 tx released", v, 8'h00);

    // R9 soft reset with no configured buffer
    @(negedge clk); txb_cfg = 4'b0000; ev_pulse = 7'h02;
    edge_sample();
    @(negedge clk); soft_rst = 1'b1;
    edge_sample(); rd(1'b0, v); check("R9 status after soft", v, 8'h00);

    // R10 asynchronous hard reset
    @(negedge clk); ev_pulse = 7'h08;
    edge_sample(); edge_sample();
    check("R10 irq before", {7'd0, irq}, 8'h01);
    #1; hard_rst_n = 1'b0;
    #0.5;
    rd(1'b0, v); check("R10 status", v, 8'h00);
    rd(1'b1, v); check("R10 enables", v, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h00);
    @(negedge clk); hard_rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule